// File: doc/BRIEF.md
# Audio Sample-Rate Classifier and Range Checker

This block watches a stream of frame-start strobes and measures how fast they arrive, using its own clock as the timing reference. That clock runs at one of six standard audio master-clock frequencies, chosen by a 3-bit code. The block counts reference cycles across a fixed number of frames. It then matches the count against nine standard audio rates and reports the nearest one as a rate code. If no rate matches, it reports an "unknown" code.

When limiting is enabled, the measured rate is compared with a set of accepted rates chosen by a 4-bit code. A doubling bit moves every accepted rate up one octave. A rate outside the accepted set raises a range error. The same condition drives a request that the clock system fall back to the reference clock. That request is also raised while no rate has been measured yet.

Any change in the measured rate between two consecutive results is reported as a temporary error that lasts one measurement window. A restart pulse discards the current result, so the next result is always treated as a change. Software uses the rate code and the error flag to decide whether the recovered clock can be trusted.

Top module: `rate_window_chk`

## Requirements
- R1: Reference code 000 means 11.2896 MHz, 001 means 12.288 MHz, 010 means 16.9344 MHz, 100 means 22.5792 MHz, 101 means 24.576 MHz and 110 means 33.8688 MHz. Codes 011 and 111 match no rate, and the result is then the unknown code 15.
- R2: The rate code is 0 for 32 kHz, 1 for 44.1, 2 for 48, 3 for 64, 4 for 88.2, 5 for 96, 6 for 128, 7 for 176.4 and 8 for 192 kHz. A count is matched when it lies within about ±3.9 % of the nominal value. A count that matches no rate gives code 15.
- R3: Each result covers FRAMES frame periods, which start at a frame strobe. After reset or restart, rateValid first rises on the cycle after the (FRAMES+1)-th frame strobe. After that, results follow back to back, one every FRAMES strobes.
- R4: With limiting enabled and doubling off, the accepted rates depend on the allowed-set code:
  - 0110 accepts 44.1 and 88.2 kHz.
  - 0000 accepts all of 32, 44.1, 48, 64, 88.2 and 96 kHz.
  - 1000 accepts 32, 44.1 and 48 kHz.
  - 0011 accepts 48 kHz only, and 0001 accepts 32 kHz only.
  - 0111 accepts 48 and 96 kHz.
  - 0010 accepts 44.1 kHz only, 0100 accepts 88.2 kHz only, and 0101 accepts 96 kHz only.
  - Codes 1001 to 1111 accept nothing.
  - The unknown code 15 is never accepted.
- R5: With dblRate high, every accepted rate of the selected set is doubled. For example, set 0101 then accepts 192 kHz, and set 0111 accepts 96 and 192 kHz but not 48 kHz.
- R6: With limitEn low, rangeErr and forceRef stay low.
- R7: With limitEn high, rangeErr is high while a valid result is outside the accepted set. forceRef is high whenever rangeErr is high and whenever no valid result exists.
- R8: A restart pulse clears rateValid and sets the rate code to 15 on the next cycle. With limitEn high, the first result after the restart raises rangeErr for one measurement window.
- R9: A result whose code differs from the previous result raises rangeErr (when limitEn is high) until the next result. rangeErr then clears if that next result repeats the same code and the code is accepted.
- R10: If no frame strobe ends a window before the cycle counter saturates, the window closes with code 15.
- R11: After reset, rateValid is low, the rate code is 15 and rangeErr is low.
- R12: A change of allowSet, dblRate or limitEn acts on rangeErr and forceRef in the same cycle, without waiting for a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the measurement time base |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe at each incoming frame start |
| refSel | input | 3 | Reference frequency code |
| limitEn | input | 1 | Enables comparison against the accepted set |
| allowSet | input | 4 | Accepted-rate set code |
| dblRate | input | 1 | Doubles every accepted rate |
| restart | input | 1 | One-cycle pulse that discards the current result |
| rateCode | output | 4 | Measured rate code, 15 when unknown |
| rateValid | output | 1 | A result exists since the last reset or restart |
| rangeErr | output | 1 | Rate outside the accepted set, or rate just changed |
| forceRef | output | 1 | Request to use the reference clock as the output source |

## Verification
The hardest states to reach are the ones where the frame stream misbehaves inside a window: a rate change that happens mid-window without a restart, and a stream that stops altogether. The bench drives frames from a free-running period generator and changes its period on the fly. It then watches rangeErr across several windows to confirm that the error appears and later clears. To stop the stream, it sets the period to zero and waits longer than the counter's saturation span, so the open window closes with the unknown code. It also tests live edits of the accepted set against a held result.

// File: rtl/rate_window_pkg.sv
package rate_window_pkg;

  localparam int NUM_RATES   = 9;
  localparam int RATE_W      = 18;
  localparam int REF_W       = 26;
  localparam int CODE_W      = 4;
  localparam int MAX_REF_HZ  = 33868800;
  localparam int MIN_RATE_HZ = 32000;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'hF;

  // strobes from the window controller to the datapath
  typedef struct packed {
    logic clr;    // open a new window, zero the counter
    logic inc;    // count this cycle
    logic fin;    // close the window, latch a result
    logic flush;  // discard the held result
  } winCtl_t;

  function automatic logic [RATE_W-1:0] rateHz(input int idx);
    case (idx)
      0:       return RATE_W'(32000);
      1:       return RATE_W'(44100);
      2:       return RATE_W'(48000);
      3:       return RATE_W'(64000);
      4:       return RATE_W'(88200);
      5:       return RATE_W'(96000);
      6:       return RATE_W'(128000);
      7:       return RATE_W'(176400);
      default: return RATE_W'(192000);
    endcase
  endfunction

  function automatic logic [REF_W-1:0] refHz(input logic [2:0] sel);
    case (sel)
      3'b000:  return REF_W'(11289600);
      3'b001:  return REF_W'(12288000);
      3'b010:  return REF_W'(16934400);
      3'b100:  return REF_W'(22579200);
      3'b101:  return REF_W'(24576000);
      3'b110:  return REF_W'(33868800);
      default: return '0;
    endcase
  endfunction

  // bit k set: base rate index k accepted (0:32k .. 5:96k)
  function automatic logic [5:0] baseMask(input logic [3:0] set);
    case (set)
      4'b0000: return 6'b111111;
      4'b0001: return 6'b000001;
      4'b0010: return 6'b000010;
      4'b0011: return 6'b000100;
      4'b0100: return 6'b010000;
      4'b0101: return 6'b100000;
      4'b0110: return 6'b010010;
      4'b0111: return 6'b100100;
      4'b1000: return 6'b000111;
      default: return 6'b000000;
    endcase
  endfunction

endpackage

// File: rtl/rate_window_ctrl.sv
module rate_window_ctrl
  import rate_window_pkg::*;
#(
  parameter int FRAMES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStb,
  input  logic    restart,
  input  logic    cntSat,
  output winCtl_t ctl
);

  localparam int FC_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [FC_W-1:0] LAST_FRM = FC_W'(FRAMES - 1);

  typedef enum logic {ST_IDLE, ST_RUN} winState_t;

  winState_t state, stateNxt;
  logic [FC_W-1:0] frm;
  logic frmClr, frmInc;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    frmClr   = 1'b0;
    frmInc   = 1'b0;
    if (restart) begin
      ctl.flush = 1'b1;
      stateNxt  = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frameStb) begin
            ctl.clr  = 1'b1;
            frmClr   = 1'b1;
            stateNxt = ST_RUN;
          end
        end
        default: begin
          if (frameStb) begin
            if (frm == LAST_FRM) begin
              ctl.fin = 1'b1;
              ctl.clr = 1'b1;
              frmClr  = 1'b1;
            end else begin
              ctl.inc = 1'b1;
              frmInc  = 1'b1;
            end
          end else if (cntSat) begin
            ctl.fin  = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            ctl.inc = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      frm   <= '0;
    end else begin
      state <= stateNxt;
      if (frmClr)      frm <= '0;
      else if (frmInc) frm <= frm + 1'b1;
    end
  end

endmodule

// File: rtl/rate_window_dp.sv
module rate_window_dp
  import rate_window_pkg::*;
#(
  parameter int FRAMES = 4,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCtl_t           ctl,
  input  logic [2:0]        refSel,
  input  logic              limitEn,
  input  logic [3:0]        allowSet,
  input  logic              dblRate,
  output logic              cntSat,
  output logic [CODE_W-1:0] rateCode,
  output logic              rateValid,
  output logic              rangeErr,
  output logic              forceRef
);

  localparam int PROD_W = CNT_W + 1 + RATE_W;

  logic [CNT_W-1:0]  count;
  logic [CNT_W:0]    measured;
  logic [PROD_W-1:0] target, tol;
  logic [REF_W-1:0]  refNow;
  logic [NUM_RATES-1:0] hit;
  logic [CODE_W-1:0] newCode;
  logic              fresh, changeHold;
  logic [15:0]       allowVec;
  logic [5:0]        mask;
  logic              allowed;

  // cycle counter for the open window
  assign cntSat = &count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   count <= '0;
    else if (ctl.clr)            count <= '0;
    else if (ctl.inc && !cntSat) count <= count + 1'b1;
  end

  // window length in cycles, including the closing cycle
  assign measured = {1'b0, count} + 1'b1;
  assign refNow   = refHz(refSel);
  assign target   = PROD_W'(refNow) * PROD_W'(FRAMES);
  assign tol      = (target >> 5) + (target >> 7);

  // one matcher per standard rate: |count*rate - ref*frames| <= tol
  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_match
    localparam logic [RATE_W-1:0] RHZ = rateHz(gi);
    logic [PROD_W-1:0] prod, diff;
    assign prod = PROD_W'(measured) * PROD_W'(RHZ);
    assign diff = (prod >= target) ? (prod - target) : (target - prod);
    assign hit[gi] = (refNow != '0) && (diff <= tol);
  end

  always_comb begin
    newCode = CODE_NONE;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hit[i]) newCode = CODE_W'(i);
    end
    if (cntSat) newCode = CODE_NONE;
  end

  // result registers and change tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCode   <= CODE_NONE;
      rateValid  <= 1'b0;
      fresh      <= 1'b1;
      changeHold <= 1'b0;
    end else if (ctl.flush) begin
      rateCode   <= CODE_NONE;
      rateValid  <= 1'b0;
      fresh      <= 1'b1;
      changeHold <= 1'b0;
    end else if (ctl.fin) begin
      rateCode   <= newCode;
      rateValid  <= 1'b1;
      changeHold <= fresh || (newCode != rateCode);
      fresh      <= 1'b0;
    end
  end

  // accepted-set check on the held result
  assign mask     = baseMask(allowSet);
  assign allowVec = dblRate ? {7'b0, mask, 3'b000} : {10'b0, mask};
  assign allowed  = allowVec[rateCode];

  assign rangeErr = limitEn && rateValid && (changeHold || !allowed);
  assign forceRef = limitEn && (!rateValid || changeHold || !allowed);

endmodule

// File: rtl/rate_window_chk.sv
module rate_window_chk
  import rate_window_pkg::*;
#(
  parameter int FRAMES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic [2:0] refSel,
  input  logic       limitEn,
  input  logic [3:0] allowSet,
  input  logic       dblRate,
  input  logic       restart,
  output logic [3:0] rateCode,
  output logic       rateValid,
  output logic       rangeErr,
  output logic       forceRef
);

  localparam int MAX_WIN = (MAX_REF_HZ / MIN_RATE_HZ + 1) * FRAMES;
  localparam int CNT_W   = $clog2(MAX_WIN) + 1;

  winCtl_t ctl;
  logic    cntSat;

  rate_window_ctrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .restart(restart),
    .cntSat(cntSat), .ctl(ctl)
  );

  rate_window_dp #(.FRAMES(FRAMES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refSel(refSel), .limitEn(limitEn),
    .allowSet(allowSet), .dblRate(dblRate), .cntSat(cntSat),
    .rateCode(rateCode), .rateValid(rateValid), .rangeErr(rangeErr),
    .forceRef(forceRef)
  );

endmodule

// File: rtl/rate_window_sva.sv
module rate_window_sva (
  input logic       clk,
  input logic       rstN,
  input logic       limitEn,
  input logic       restart,
  input logic [3:0] rateCode,
  input logic       rateValid,
  input logic       rangeErr,
  input logic       forceRef
);

  // R6
  no_err_unlimited_chk: assert property (@(posedge clk) disable iff (!rstN)
    !limitEn |-> (!rangeErr && !forceRef));

  // R7
  err_forces_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> forceRef);

  // R7
  no_result_forces_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limitEn && !rateValid) |-> forceRef);

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!rateValid && rateCode == 4'hF));

  // R3
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateValid && !restart) |=> rateValid);

  // R8
  first_result_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rateValid) && limitEn) |-> rangeErr);

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> (rateCode <= 4'd8 || rateCode == 4'hF));

endmodule

bind rate_window_chk rate_window_sva u_sva (
  .clk(clk), .rstN(rstN), .limitEn(limitEn), .restart(restart),
  .rateCode(rateCode), .rateValid(rateValid), .rangeErr(rangeErr),
  .forceRef(forceRef)
);

// File: tb/rate_window_chk_bench.sv
module rate_window_chk_bench;

  localparam int FR = 2;

  typedef struct packed {
    logic [2:0]  refSel;
    logic [17:0] rateHz;
    logic        lim;
    logic [3:0]  aSet;
    logic        dbl;
    logic [3:0]  expCode;
    logic        expErr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 18'd44100,  1'b0, 4'd0, 1'b0, 4'd1,  1'b0},
    '{3'd1, 18'd48000,  1'b1, 4'd3, 1'b0, 4'd2,  1'b0},
    '{3'd2, 18'd32000,  1'b1, 4'd1, 1'b0, 4'd0,  1'b0},
    '{3'd4, 18'd96000,  1'b1, 4'd2, 1'b0, 4'd5,  1'b1},
    '{3'd5, 18'd88200,  1'b1, 4'd6, 1'b0, 4'd4,  1'b0},
    '{3'd6, 18'd192000, 1'b1, 4'd5, 1'b1, 4'd8,  1'b0},
    '{3'd0, 18'd176400, 1'b1, 4'd4, 1'b1, 4'd7,  1'b0},
    '{3'd1, 18'd64000,  1'b1, 4'd0, 1'b0, 4'd3,  1'b0},
    '{3'd1, 18'd128000, 1'b1, 4'd0, 1'b0, 4'd6,  1'b1},
    '{3'd4, 18'd40000,  1'b1, 4'd0, 1'b0, 4'd15, 1'b1},
    '{3'd4, 18'd40000,  1'b0, 4'd0, 1'b0, 4'd15, 1'b0},
    '{3'd2, 18'd48000,  1'b1, 4'd8, 1'b0, 4'd2,  1'b0},
    '{3'd2, 18'd96000,  1'b1, 4'd8, 1'b0, 4'd5,  1'b1},
    '{3'd5, 18'd48000,  1'b1, 4'd9, 1'b0, 4'd2,  1'b1},
    '{3'd0, 18'd48000,  1'b1, 4'd7, 1'b1, 4'd2,  1'b1},
    '{3'd6, 18'd32000,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0},
    '{3'd3, 18'd48000,  1'b1, 4'd0, 1'b0, 4'd15, 1'b1}   // R1: unused ref code
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameStb = 1'b0;
  logic [2:0] refSel;
  logic       limitEn;
  logic [3:0] allowSet;
  logic       dblRate;
  logic       restart;
  logic [3:0] rateCode;
  logic       rateValid, rangeErr, forceRef;

  int totalChk = 0;
  int badChk   = 0;
  int period   = 0;
  int phase    = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  // free-running frame generator, one strobe every 'period' cycles
  always @(negedge clk) begin
    if (period == 0) begin
      frameStb <= 1'b0;
      phase    <= 0;
    end else if (phase >= period - 1) begin
      frameStb <= 1'b1;
      phase    <= 0;
    end else begin
      frameStb <= 1'b0;
      phase    <= phase + 1;
    end
  end

  rate_window_chk #(.FRAMES(FR)) u_rate_window_chk (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .refSel(refSel),
    .limitEn(limitEn), .allowSet(allowSet), .dblRate(dblRate),
    .restart(restart), .rateCode(rateCode), .rateValid(rateValid),
    .rangeErr(rangeErr), .forceRef(forceRef)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      badChk = badChk + 1;
      $display("FAIL R3 watchdog expired actual=%0d expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", totalChk + 1, badChk);
      $finish;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    totalChk++;
    if (act !== exp) begin
      badChk++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int refHzOf(input logic [2:0] sel);
    case (sel)
      3'd0: return 11289600;
      3'd1: return 12288000;
      3'd2: return 16934400;
      3'd4: return 22579200;
      3'd5: return 24576000;
      3'd6: return 33868800;
      default: return 0;
    endcase
  endfunction

  task automatic runVec(input vec_t v);
    int rHz, per, strobes;
    string codeTag, errTag;
    rHz = refHzOf(v.refSel);
    codeTag = (rHz == 0) ? "R1" : "R2";
    if (rHz == 0) rHz = 12288000;
    errTag = !v.lim ? "R6" : (v.dbl ? "R5" : "R4");
    per = (rHz + int'(v.rateHz) / 2) / int'(v.rateHz);
    @(negedge clk);
    refSel = v.refSel; limitEn = v.lim; allowSet = v.aSet; dblRate = v.dbl;
    period = per;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R8", "valid after restart", rateValid, 0);
    check("R8", "code after restart", rateCode, 15);
    check("R7", "forceRef without result", forceRef, v.lim);
    strobes = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      strobes += int'(frameStb);
      if (rateValid) break;
    end
    check("R3", "strobes until first result", strobes, FR + 1);
    check(codeTag, "rate code", rateCode, v.expCode);
    check("R8", "temporary error on first result", rangeErr, v.lim);
    repeat (FR * per + per / 2) @(negedge clk);
    check(errTag, "steady range error", rangeErr, v.expErr);
    check("R7", "steady forceRef", forceRef, v.expErr);
    check(codeTag, "steady rate code", rateCode, v.expCode);
  endtask

  initial begin
    int sawErr;
    rstN = 1'b0; refSel = 3'd0; limitEn = 1'b1; allowSet = 4'd0;
    dblRate = 1'b0; restart = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "valid at reset", rateValid, 0);
    check("R11", "code at reset", rateCode, 15);
    check("R11", "rangeErr at reset", rangeErr, 0);
    check("R7", "forceRef at reset", forceRef, 1);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R9: rate change without restart, 44.1k -> 48k on 11.2896 MHz
    runVec('{3'd0, 18'd44100, 1'b1, 4'd0, 1'b0, 4'd1, 1'b0});
    period = 235;
    sawErr = 0;
    for (int k = 0; k < 5 * FR * 235; k++) begin
      @(negedge clk);
      if (rangeErr) sawErr = 1;
    end
    check("R9", "error seen after rate change", sawErr, 1);
    check("R9", "error cleared after repeat", rangeErr, 0);
    check("R9", "new rate code", rateCode, 2);

    // R12: live edit of accepted set and doubling against held result
    allowSet = 4'd1;
    @(negedge clk);
    check("R12", "allowSet edit raises error", rangeErr, 1);
    allowSet = 4'd3;
    @(negedge clk);
    check("R12", "allowSet 48-only clears error", rangeErr, 0);
    dblRate = 1'b1;
    @(negedge clk);
    check("R12", "doubling rejects 48k", rangeErr, 1);
    dblRate = 1'b0;
    limitEn = 1'b0;
    allowSet = 4'd1;
    @(negedge clk);
    check("R12", "limit off drops error", rangeErr, 0);
    check("R6", "limit off drops forceRef", forceRef, 0);
    limitEn = 1'b1;
    allowSet = 4'd0;

    // R10: stream stops, open window saturates
    period = 0;
    repeat (9000) @(negedge clk);
    check("R10", "saturated code", rateCode, 15);
    check("R10", "valid kept", rateValid, 1);
    check("R10", "saturated error", rangeErr, 1);

    $display("  test done: total=%0d bad=%0d", totalChk, badChk);
    $finish;
  end

endmodule